// File: doc/BRIEF.md
# Far Transfer Privilege Checker

This block judges one far control transfer in a segmented protected-mode processor. For each request it receives the current privilege level, the 16-bit selector named by the instruction, the kind of transfer, the nested-task flag and two already-fetched 8-byte descriptors. The first descriptor is the one the selector names. The second is the segment or task-state descriptor that a gate points to, and it is consulted only when the first is a gate. Fetching, context save and restore, and register loading happen elsewhere.

The block sorts the transfer into one of five classes:

- a direct segment transfer,
- a call-gate transfer,
- a task switch,
- a fast system-call entry or exit,
- a plain interrupt return.

It then applies the privilege rules in a fixed order. It reports a fault code, the privilege level that will be in force afterwards, a stack-switch request and a task-switch request. The result is registered and appears one cycle after the input strobe, and a new request can be accepted on every cycle.

Control is a two-state machine:

- **ST_IDLE**: no result is shown.
- **ST_REPORT**: a result is shown for one cycle.

The transitions are:

- **IDLE→REPORT**: the strobe is high.
- **REPORT→REPORT**: a back-to-back strobe arrives.
- **REPORT→IDLE**: the strobe is low.
- **IDLE→IDLE**: no strobe.

Top module: `fxp_priv_check`

## Requirements
- R1: The result appears with `out_valid` high exactly one cycle after a cycle with `in_valid` high. `out_valid` is low in the cycle after any cycle with `in_valid` low, and it is low during reset.
- R2: The selector fields are: bits 1:0 give the requestor level (RPL), and bit 2 chooses the table (1 = local, 0 = global). The descriptor fields are: bit 47 present, bits 46:45 DPL, bit 44 S (1 = code/data), bits 43:40 type. For S=1, bit 43 marks code and bit 42 marks conforming. All other bits are ignored.
- R3: A call or jump (op 0/1) to a non-conforming code descriptor passes only when CPL == DPL and RPL <= CPL; otherwise it is GP. On success the class is 0 (direct), the new level equals CPL and there is no stack switch.
- R4: A call or jump to a conforming code descriptor passes only when DPL <= CPL, whatever the RPL. The class is 0 and the new level stays CPL.
- R5: A call or jump to a data descriptor (S=1, bit 43 clear) or to a system descriptor that is neither a call gate (type 1100), a task gate (type 0101) nor an available TSS (type 1001) gives GP with class 0. This includes a busy TSS (type 1011).
- R6: For a call gate, the checks are applied in this order, and the first check that fails gives GP:
  1. max(CPL,RPL) <= gate DPL;
  2. the gate is present (otherwise NP, see R13);
  3. the target is a code descriptor;
  4. target DPL <= CPL.

  The class is 1.
- R7: A call-gate transfer that passes to a non-conforming target takes the target DPL as the new level, and requests a stack switch exactly when that DPL differs from CPL. A conforming target keeps CPL and requests no stack switch.
- R8: A jump (op 1) through a call gate to a non-conforming target more privileged than CPL gives GP.
- R9: A call or jump to an available TSS is class 2. It gives GP when its table bit is 1 (local table) or when max(CPL,RPL) > DPL. Otherwise it requests a task switch.
- R10: A call or jump through a task gate is class 2 and first requires max(CPL,RPL) <= gate DPL. After the gate's own present check, the target must be an available TSS, or the result is GP. A transfer that passes requests a task switch.
- R11: An interrupt (op 2) is class 2 and needs a task gate, with no privilege check; otherwise it gives GP. The target must be an available TSS. An interrupt return (op 3) with the nested-task flag set requests a task switch (class 2). With the flag clear it is class 4, with no request and no fault. Descriptors are ignored for op 3.
- R12: Fast entry (op 4) always passes with new level 0. Fast exit (op 5) gives GP unless CPL is 0, and otherwise sets the new level to 3. Both are class 3, request neither switch, and ignore the descriptors and the selector.
- R13: The fault codes are 0 none, 1 GP and 2 NP. For each descriptor, its GP checks come before its present check, and the gate is judged before its target. On any fault both requests are low and the new level equals CPL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 3 | Transfer kind: 0 call, 1 jump, 2 interrupt, 3 interrupt return, 4 fast entry, 5 fast exit |
| in_cpl | input | 2 | Current privilege level |
| in_sel | input | 16 | Selector from the instruction |
| in_nt | input | 1 | Nested-task flag |
| in_sel_desc | input | 64 | Descriptor named by the selector (or the interrupt-table entry) |
| in_tgt_desc | input | 64 | Descriptor the gate points to |
| out_valid | output | 1 | Result valid |
| out_fault | output | 2 | Fault code |
| out_class | output | 3 | Transfer class: 0 direct, 1 gate, 2 task, 3 fast, 4 return |
| out_new_pl | output | 2 | Privilege level after the transfer |
| out_stack_sw | output | 1 | Stack-switch request |
| out_task_sw | output | 1 | Task-switch request |

## Verification
The bench builds the block with its default parameters: 2-bit privilege levels, 16-bit selectors and 64-bit descriptors. With privileges this narrow, every combination of CPL, RPL and descriptor DPL can be swept for every transfer kind. The sweep covers seven selector-descriptor kinds with both present states. For gates it also covers every target kind, target DPL and target present state. This reaches every fault-ordering corner, including:

- a jump through a call gate,
- a TSS in the local table,
- a busy TSS,
- fast exit from a nonzero level.

The unused descriptor bits carry a varying filler pattern, which shows that they are ignored.

// File: rtl/fxp_pkg.sv
package fxp_pkg;

    localparam int PL_W     = 2;
    localparam int SEL_W    = 16;
    localparam int DESC_W   = 64;

    localparam int SEL_TI   = 2;
    localparam int D_TYP_LO = 40;
    localparam int D_S      = D_TYP_LO + 4;
    localparam int D_DPL_LO = D_S + 1;
    localparam int D_P      = D_DPL_LO + PL_W;

    localparam logic [3:0] T_TSS_AVL   = 4'b1001;
    localparam logic [3:0] T_CALL_GATE = 4'b1100;
    localparam logic [3:0] T_TASK_GATE = 4'b0101;

    typedef logic [PL_W-1:0] pl_t;

    typedef enum logic [2:0] {
        OP_CALL   = 3'd0,
        OP_JMP    = 3'd1,
        OP_INT    = 3'd2,
        OP_IRET   = 3'd3,
        OP_FENTER = 3'd4,
        OP_FEXIT  = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_GP   = 2'd1,
        FLT_NP   = 2'd2
    } flt_e;

    typedef enum logic [2:0] {
        CLS_DIRECT = 3'd0,
        CLS_GATE   = 3'd1,
        CLS_TASK   = 3'd2,
        CLS_FAST   = 3'd3,
        CLS_RET    = 3'd4
    } cls_e;

    typedef struct packed {
        logic       present;
        pl_t        dpl;
        logic       seg;
        logic       code;
        logic       conf;
        logic [3:0] typ;
    } dinfo_t;

    typedef struct packed {
        flt_e fault;
        cls_e cls;
        pl_t  new_pl;
        logic stk;
        logic tsk;
    } verdict_t;

    function automatic pl_t pl_max(input pl_t a, input pl_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fxp_desc_decode.sv
module fxp_desc_decode
    import fxp_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    output dinfo_t            info
);
    localparam int HI_LO = D_P + 1;

    logic unused_desc_bits;
    assign unused_desc_bits = ^{desc[DESC_W-1:HI_LO], desc[D_TYP_LO-1:0]};

    always_comb begin
        info.present = desc[D_P];
        info.dpl     = desc[D_DPL_LO +: PL_W];
        info.seg     = desc[D_S];
        info.typ     = desc[D_TYP_LO +: 4];
        info.code    = desc[D_TYP_LO + 3];
        info.conf    = desc[D_TYP_LO + 2];
    end
endmodule

// File: rtl/fxp_rule_eval.sv
module fxp_rule_eval
    import fxp_pkg::*;
(
    input  op_e      op,
    input  pl_t      cpl,
    input  pl_t      rpl,
    input  logic     ti,
    input  logic     nt,
    input  dinfo_t   sd,
    input  dinfo_t   td,
    output verdict_t v
);
    pl_t  req;
    logic sel_cg, sel_tg, sel_tss, tgt_code, tgt_tss;

    always_comb begin
        req      = pl_max(cpl, rpl);
        sel_cg   = !sd.seg && (sd.typ == T_CALL_GATE);
        sel_tg   = !sd.seg && (sd.typ == T_TASK_GATE);
        sel_tss  = !sd.seg && (sd.typ == T_TSS_AVL);
        tgt_code = td.seg && td.code;
        tgt_tss  = !td.seg && (td.typ == T_TSS_AVL);
    end

    always_comb begin
        v.fault  = FLT_NONE;
        v.cls    = CLS_DIRECT;
        v.new_pl = cpl;
        v.stk    = 1'b0;
        v.tsk    = 1'b0;
        unique case (op)
            OP_CALL, OP_JMP: begin
                if (sd.seg) begin
                    if (!sd.code)
                        v.fault = FLT_GP;
                    else if (sd.conf ? (sd.dpl > cpl) : ((sd.dpl != cpl) || (rpl > cpl)))
                        v.fault = FLT_GP;
                    else if (!sd.present)
                        v.fault = FLT_NP;
                end else if (sel_cg) begin
                    v.cls = CLS_GATE;
                    if (req > sd.dpl)
                        v.fault = FLT_GP;
                    else if (!sd.present)
                        v.fault = FLT_NP;
                    else if (!tgt_code || (td.dpl > cpl))
                        v.fault = FLT_GP;
                    else if ((op == OP_JMP) && !td.conf && (td.dpl != cpl))
                        v.fault = FLT_GP;
                    else if (!td.present)
                        v.fault = FLT_NP;
                    else if (!td.conf) begin
                        v.new_pl = td.dpl;
                        v.stk    = (td.dpl != cpl);
                    end
                end else if (sel_tg) begin
                    v.cls = CLS_TASK;
                    if (req > sd.dpl)
                        v.fault = FLT_GP;
                    else if (!sd.present)
                        v.fault = FLT_NP;
                    else if (!tgt_tss)
                        v.fault = FLT_GP;
                    else if (!td.present)
                        v.fault = FLT_NP;
                    else
                        v.tsk = 1'b1;
                end else if (sel_tss) begin
                    v.cls = CLS_TASK;
                    if (ti || (req > sd.dpl))
                        v.fault = FLT_GP;
                    else if (!sd.present)
                        v.fault = FLT_NP;
                    else
                        v.tsk = 1'b1;
                end else begin
                    v.fault = FLT_GP;
                end
            end
            OP_INT: begin
                v.cls = CLS_TASK;
                if (!sel_tg)
                    v.fault = FLT_GP;
                else if (!sd.present)
                    v.fault = FLT_NP;
                else if (!tgt_tss)
                    v.fault = FLT_GP;
                else if (!td.present)
                    v.fault = FLT_NP;
                else
                    v.tsk = 1'b1;
            end
            OP_IRET: begin
                if (nt) begin
                    v.cls = CLS_TASK;
                    v.tsk = 1'b1;
                end else begin
                    v.cls = CLS_RET;
                end
            end
            OP_FENTER: begin
                v.cls    = CLS_FAST;
                v.new_pl = '0;
            end
            OP_FEXIT: begin
                v.cls = CLS_FAST;
                if (cpl != '0)
                    v.fault = FLT_GP;
                else
                    v.new_pl = '1;
            end
            default: v.fault = FLT_GP;
        endcase
    end
endmodule

// File: rtl/fxp_priv_check.sv
module fxp_priv_check
    import fxp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        in_op,
    input  logic [PL_W-1:0]   in_cpl,
    input  logic [SEL_W-1:0]  in_sel,
    input  logic              in_nt,
    input  logic [DESC_W-1:0] in_sel_desc,
    input  logic [DESC_W-1:0] in_tgt_desc,
    output logic              out_valid,
    output logic [1:0]        out_fault,
    output logic [2:0]        out_class,
    output logic [PL_W-1:0]   out_new_pl,
    output logic              out_stack_sw,
    output logic              out_task_sw
);
    typedef enum logic {ST_IDLE, ST_REPORT} state_e;

    state_e   state_q, state_d;
    dinfo_t   sel_info, tgt_info;
    verdict_t verdict, res_q;

    logic unused_sel_index;
    assign unused_sel_index = ^in_sel[SEL_W-1:SEL_TI+1];

    fxp_desc_decode u_sel_dec (.desc(in_sel_desc), .info(sel_info));
    fxp_desc_decode u_tgt_dec (.desc(in_tgt_desc), .info(tgt_info));

    fxp_rule_eval u_eval (
        .op  (op_e'(in_op)),
        .cpl (in_cpl),
        .rpl (in_sel[PL_W-1:0]),
        .ti  (in_sel[SEL_TI]),
        .nt  (in_nt),
        .sd  (sel_info),
        .td  (tgt_info),
        .v   (verdict)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = in_valid ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            res_q <= '{fault: FLT_NONE, cls: CLS_DIRECT, new_pl: '0, stk: 1'b0, tsk: 1'b0};
        else if (in_valid)
            res_q <= verdict;
    end

    always_comb begin
        out_valid    = (state_q == ST_REPORT);
        out_fault    = res_q.fault;
        out_class    = res_q.cls;
        out_new_pl   = res_q.new_pl;
        out_stack_sw = res_q.stk;
        out_task_sw  = res_q.tsk;
    end

    p_strobe_to_result_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_no_spurious_result_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_fault_is_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fault != 2'd0) |->
            (!out_stack_sw && !out_task_sw && out_new_pl == $past(in_cpl)));

    p_fault_code_legal_r13: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_fault != 2'd3));

    p_direct_keeps_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class == 3'd0) |->
            (out_new_pl == $past(in_cpl) && !out_stack_sw && !out_task_sw));

    p_stack_only_on_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_stack_sw) |->
            (out_class == 3'd1 && out_new_pl < $past(in_cpl)));

    p_task_class_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_task_sw) |-> (out_class == 3'd2 && !out_stack_sw));

    p_fast_levels_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class == 3'd3 && out_fault == 2'd0) |->
            ((out_new_pl == '0 && $past(in_op) == 3'd4) ||
             (out_new_pl == '1 && $past(in_op) == 3'd5)));
endmodule

// File: tb/fxp_priv_check_tb_top.sv
`timescale 1ns/1ps
module fxp_priv_check_tb_top;

    localparam int K_DATA = 0, K_CNC = 1, K_CCF = 2, K_CGATE = 3,
                   K_TGATE = 4, K_TSSA = 5, K_TSSB = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = '0;
    logic [1:0]  in_cpl = '0;
    logic [15:0] in_sel = '0;
    logic        in_nt = 1'b0;
    logic [63:0] in_sel_desc = '0;
    logic [63:0] in_tgt_desc = '0;
    logic        out_valid, out_stack_sw, out_task_sw;
    logic [1:0]  out_fault, out_new_pl;
    logic [2:0]  out_class;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fxp_priv_check dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_cpl(in_cpl), .in_sel(in_sel), .in_nt(in_nt),
        .in_sel_desc(in_sel_desc), .in_tgt_desc(in_tgt_desc),
        .out_valid(out_valid), .out_fault(out_fault), .out_class(out_class),
        .out_new_pl(out_new_pl), .out_stack_sw(out_stack_sw), .out_task_sw(out_task_sw)
    );

    // R2 layout: [47] present, [46:45] DPL, [44] S, [43:40] type; rest filler
    function automatic logic [63:0] mk_desc(int kind, int dpl, int p, int fill);
        logic [3:0] typ;
        logic       s;
        case (kind)
            K_DATA:  begin s = 1'b1; typ = 4'b0010; end
            K_CNC:   begin s = 1'b1; typ = 4'b1010; end
            K_CCF:   begin s = 1'b1; typ = 4'b1110; end
            K_CGATE: begin s = 1'b0; typ = 4'b1100; end
            K_TGATE: begin s = 1'b0; typ = 4'b0101; end
            K_TSSA:  begin s = 1'b0; typ = 4'b1001; end
            default: begin s = 1'b0; typ = 4'b1011; end
        endcase
        return {16'(fill * 16'h9E37), 1'(p), 2'(dpl), s, typ, 40'(fill * 40'h1F3D5B79A1)};
    endfunction

    // returns {fault[1:0], class[2:0], new_pl[1:0], stack, task}
    function automatic logic [8:0] ref_model(int op, int cpl, int rpl, int ti, int nt,
                                             int sk, int sdpl, int sp,
                                             int tk, int tdpl, int tp);
        int f = 0, cls = 0, npl = cpl, stk = 0, tsk = 0;
        int req = (cpl > rpl) ? cpl : rpl;
        bit tcode = (tk == K_CNC) || (tk == K_CCF);
        bit tconf = (tk == K_CCF);
        bit ttss  = (tk == K_TSSA);
        if (op == 0 || op == 1) begin
            if (sk == K_DATA || sk == K_TSSB) f = 1;
            else if (sk == K_CNC) begin
                if (sdpl != cpl || rpl > cpl) f = 1; else if (sp == 0) f = 2;
            end else if (sk == K_CCF) begin
                if (sdpl > cpl) f = 1; else if (sp == 0) f = 2;
            end else if (sk == K_CGATE) begin
                cls = 1;
                if (req > sdpl) f = 1;
                else if (sp == 0) f = 2;
                else if (!tcode) f = 1;
                else if (tdpl > cpl) f = 1;
                else if (op == 1 && !tconf && tdpl < cpl) f = 1;
                else if (tp == 0) f = 2;
                else if (!tconf) begin npl = tdpl; stk = (tdpl < cpl) ? 1 : 0; end
            end else if (sk == K_TGATE) begin
                cls = 2;
                if (req > sdpl) f = 1;
                else if (sp == 0) f = 2;
                else if (!ttss) f = 1;
                else if (tp == 0) f = 2;
                else tsk = 1;
            end else begin
                cls = 2;
                if (ti == 1 || req > sdpl) f = 1;
                else if (sp == 0) f = 2;
                else tsk = 1;
            end
        end else if (op == 2) begin
            cls = 2;
            if (sk != K_TGATE) f = 1;
            else if (sp == 0) f = 2;
            else if (!ttss) f = 1;
            else if (tp == 0) f = 2;
            else tsk = 1;
        end else if (op == 3) begin
            if (nt == 1) begin cls = 2; tsk = 1; end else cls = 4;
        end else if (op == 4) begin
            cls = 3; npl = 0;
        end else begin
            cls = 3;
            if (cpl != 0) f = 1; else npl = 3;
        end
        return {2'(f), 3'(cls), 2'(npl), 1'(stk), 1'(tsk)};
    endfunction

    function automatic string req_tag(int op, int sk);
        if (op == 2 || op == 3) return "R11";
        if (op >= 4) return "R12";
        case (sk)
            K_DATA:  return "R5";
            K_CNC:   return "R3 R2";
            K_CCF:   return "R4";
            K_CGATE: return (op == 1) ? "R8 R6 R7" : "R6 R7";
            K_TGATE: return "R10";
            K_TSSA:  return "R9 R2";
            default: return "R5 R9";
        endcase
    endfunction

    task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got fault/class/pl/stk/tsk=%b expected %b", tag, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        // R1: reset state, strobe held high during reset
        @(negedge clk);
        in_valid = 1'b1;
        @(posedge clk); #1;
        check("R1 reset", {out_valid, out_fault, out_class, out_new_pl, out_stack_sw, out_task_sw}, 10'd0);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 idle after reset", {8'd0, out_valid}, 9'd0);

        for (int op = 0; op < 6; op++)
        for (int cpl = 0; cpl < 4; cpl++)
        for (int rpl = 0; rpl < 4; rpl++)
        for (int sk = 0; sk < 7; sk++)
        for (int sdpl = 0; sdpl < 4; sdpl++)
        for (int sp = 0; sp < 2; sp++) begin
            int tmax = (sk == K_CGATE || sk == K_TGATE) ? 32 : 1;
            for (int tv = 0; tv < tmax; tv++) begin
                int tk_i = tv >> 3;
                int tk   = (tk_i == 0) ? K_CNC : (tk_i == 1) ? K_CCF : (tk_i == 2) ? K_DATA : K_TSSA;
                int tdpl = (tv >> 1) & 3;
                int tp   = tv & 1;
                int ti   = (sdpl & 1) ^ (cpl >> 1) ^ sp;
                int nt   = sp ^ (rpl & 1);
                int fill = op * 131 + cpl * 37 + rpl * 11 + sk * 7 + sdpl * 3 + tv + 1;
                logic [8:0] exp;
                @(negedge clk);
                in_valid    = 1'b1;
                in_op       = 3'(op);
                in_cpl      = 2'(cpl);
                in_sel      = {13'(fill), 1'(ti), 2'(rpl)};
                in_nt       = 1'(nt);
                in_sel_desc = mk_desc(sk, sdpl, sp, fill);
                in_tgt_desc = mk_desc(tk, tdpl, tp, fill + 5);
                exp = ref_model(op, cpl, rpl, ti, nt, sk, sdpl, sp, tk, tdpl, tp);
                @(posedge clk); #1;
                if (!out_valid) check("R1 valid", 9'd0, 9'd1);
                else begin
                    string tag = req_tag(op, sk);
                    if (exp[8:7] == 2'd2) tag = {tag, " R13"};
                    check(tag, {out_fault, out_class, out_new_pl, out_stack_sw, out_task_sw}, exp);
                end
            end
        end

        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk); #1;
        check("R1 drop", {8'd0, out_valid}, 9'd0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog R1: got no end, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule